// File: doc/BRIEF.md
# TLB Dirty-Bit Write Trap Unit

This block sits beside a TLB lookup and watches every store that passes through it. When a store hits a valid entry whose access rights allow the write but whose dirty bit is still clear, the block raises an initial-page-write trap. The store is not committed. In one clock edge the block then updates every register involved in the trap:

- the page-table-entry-high register, the fault-address register and the exception-code register;
- the saved program counter and the saved status;
- the status flags and the way field of the MMU control register.

It also produces the handler fetch address.

The trap handler then does the rest in software. It stages a new entry with the dirty bit set in the page-table-entry registers. It may pick a different way by rewriting the way field. It then issues a load-TLB command, and the block presents the staged entry to the TLB array as a write on the next cycle. The TLB array, the page-table walk and the CPU pipeline are outside the block and appear only as ports. Software reaches the staged registers through a small register write port.

Top module: `dtrap_top`

## Requirements
- R1: A trap is taken when `accValid`, `accWrite`, `tlbHit` and `tlbRightsOk` are 1, `tlbDirty` is 0, and status bit 28 (block) is 0. `trapTaken` then pulses high for exactly the following cycle. In every other case, including reads and stores to dirty entries, `trapTaken` stays 0.
- R2: A miss (`tlbHit`=0) or a rights failure (`tlbRightsOk`=0) suppresses the trap in that cycle. `storeCommit` is combinational and is 1 only for a valid store that hits, has rights and finds the dirty bit at 1, so a trapping store never commits.
- R3: On a trap, bits 31:12 of `pteHiOut` take bits 31:12 of `accAddr`, and bits 11:0 of `pteHiOut` keep their old value. `faultAddrOut` takes the full `accAddr`.
- R4: On a trap, `expCodeOut` becomes 0x080.
- R5: On a trap, `savedPcOut` becomes `accPc`. When `accDelaySlot` is 1 it becomes `accBranchPc` instead.
- R6: On a trap, `savedSrOut` takes the status value from before the trap. `srOut` keeps its other bits and has bits 30 (privileged), 29 (bank) and 28 (block) set to 1.
- R7: On a trap, `rcWayOut` takes `tlbWay`.
- R8: In the cycle `trapTaken` is 1, `branchTarget` equals the vector base register plus 0x100.
- R9: If the trap condition occurs while status bit 28 is 1, `stuckFault` pulses for the following cycle. No trap is taken, and no trap register changes.
- R10: When `ldtlbCmd` is 1, `tlbWrEn` is 1 on the following cycle. In that cycle `tlbWrHi` and `tlbWrLo` carry the page-table-entry-high and page-table-entry-low values, and `tlbWrWay` carries `rcWayOut`, all as they stood when the command was given.
- R11: When `regWe` is 1, the register write port selects its target by `regSel`: 0 writes page-table-entry-high, 1 writes page-table-entry-low, 2 writes status, 3 writes the vector base register, and 4 writes the way field from `regWdata[1:0]`. Other codes write nothing. A trap in the same cycle wins, and the write is dropped.
- R12: After reset all registers are zero, and `trapTaken`, `stuckFault` and `tlbWrEn` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | Access present this cycle |
| accWrite | input | 1 | Access is a store |
| accAddr | input | 32 | Logical address of the access |
| accPc | input | 32 | Address of the accessing instruction |
| accDelaySlot | input | 1 | Access comes from a delay-slot instruction |
| accBranchPc | input | 32 | Address of the related delayed branch |
| tlbHit | input | 1 | Lookup matched a valid entry |
| tlbRightsOk | input | 1 | Entry grants the access |
| tlbDirty | input | 1 | Dirty bit of the matched entry |
| tlbWay | input | 2 | Way of the matched entry |
| ldtlbCmd | input | 1 | Load-TLB command |
| regWe | input | 1 | Register write strobe |
| regSel | input | 3 | Register write target |
| regWdata | input | 32 | Register write data |
| storeCommit | output | 1 | Store may commit this cycle |
| trapTaken | output | 1 | Trap taken on the previous edge |
| stuckFault | output | 1 | Trap condition seen while blocked |
| branchTarget | output | 32 | Handler fetch address |
| pteHiOut | output | 32 | Page-table-entry high register |
| pteLoOut | output | 32 | Page-table-entry low register |
| faultAddrOut | output | 32 | Fault-address register |
| expCodeOut | output | 12 | Exception code register |
| savedPcOut | output | 32 | Saved program counter |
| savedSrOut | output | 32 | Saved status |
| srOut | output | 32 | Status register |
| vbrOut | output | 32 | Vector base register |
| rcWayOut | output | 2 | Way field of the MMU control register |
| tlbWrEn | output | 1 | TLB entry write strobe |
| tlbWrWay | output | 2 | Way to write |
| tlbWrHi | output | 32 | Entry high word to write |
| tlbWrLo | output | 32 | Entry low word to write |

## Verification
`storeCommit` is combinational and is due in the same cycle as its inputs. The bench checks it one nanosecond after driving those inputs, before the next edge.

The other results each pass through one register and are due on the edge after the stimulus. These are the trap and stuck pulses, every trap register, the register-port writes and the TLB write. The bench drives each input on a falling edge and computes the next state from its own model of the requirements. It compares every output one nanosecond after the following rising edge. Data fields that only mean something alongside a strobe (`branchTarget`, the TLB write words) are compared only while that strobe is high.

// File: rtl/dtrap_pkg.sv
package dtrap_pkg;
  localparam int SR_MD = 30;
  localparam int SR_RB = 29;
  localparam int SR_BL = 28;

  typedef enum logic [2:0] {
    SEL_PTEHI = 3'd0,
    SEL_PTELO = 3'd1,
    SEL_SR    = 3'd2,
    SEL_VBR   = 3'd3,
    SEL_RC    = 3'd4
  } regSel_e;

  typedef struct packed {
    logic trap;
    logic stuck;
    logic load;
    logic regWr;
  } dtrapStrobe_t;
endpackage

// File: rtl/dtrap_ctrl.sv
module dtrap_ctrl
  import dtrap_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         accValid,
  input  logic         accWrite,
  input  logic         tlbHit,
  input  logic         tlbRightsOk,
  input  logic         tlbDirty,
  input  logic         blocked,
  input  logic         ldtlbCmd,
  input  logic         regWe,
  output dtrapStrobe_t strobe,
  output logic         storeCommit,
  output logic         trapTaken,
  output logic         stuckFault
);
  logic storeGranted;
  logic cleanHit;

  // miss or rights failure gates out both commit and trap
  assign storeGranted = accValid && accWrite && tlbHit && tlbRightsOk;
  assign cleanHit     = storeGranted && !tlbDirty;
  assign storeCommit  = storeGranted && tlbDirty;

  always_comb begin
    strobe.trap  = cleanHit && !blocked;
    strobe.stuck = cleanHit && blocked;
    strobe.load  = ldtlbCmd;
    strobe.regWr = regWe && !strobe.trap;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trapTaken  <= 1'b0;
      stuckFault <= 1'b0;
    end else begin
      trapTaken  <= strobe.trap;
      stuckFault <= strobe.stuck;
    end
  end
endmodule

// File: rtl/dtrap_dp.sv
module dtrap_dp
  import dtrap_pkg::*;
#(
  parameter int AW        = 32,
  parameter int WAYS      = 4,
  parameter int PAGE_BITS = 12,
  parameter int CODE_W    = 12,
  parameter logic [CODE_W-1:0] EXC_CODE = 12'h080,
  parameter logic [AW-1:0] VEC_OFS = 32'h100,
  localparam int WAY_W = $clog2(WAYS)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  dtrapStrobe_t     strobe,
  input  logic [AW-1:0]    accAddr,
  input  logic [AW-1:0]    accPc,
  input  logic             accDelaySlot,
  input  logic [AW-1:0]    accBranchPc,
  input  logic [WAY_W-1:0] tlbWay,
  input  logic [2:0]       regSel,
  input  logic [AW-1:0]    regWdata,
  output logic [AW-1:0]    branchTarget,
  output logic [AW-1:0]    pteHi,
  output logic [AW-1:0]    pteLo,
  output logic [AW-1:0]    faultAddr,
  output logic [CODE_W-1:0] expCode,
  output logic [AW-1:0]    savedPc,
  output logic [AW-1:0]    savedSr,
  output logic [AW-1:0]    sr,
  output logic [AW-1:0]    vbr,
  output logic [WAY_W-1:0] rcWay,
  output logic             tlbWrEn,
  output logic [WAY_W-1:0] tlbWrWay,
  output logic [AW-1:0]    tlbWrHi,
  output logic [AW-1:0]    tlbWrLo
);
  logic [AW-1:0] srTrapMask;
  always_comb begin
    srTrapMask = '0;
    srTrapMask[SR_MD] = 1'b1;
    srTrapMask[SR_RB] = 1'b1;
    srTrapMask[SR_BL] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pteHi <= '0; pteLo <= '0; faultAddr <= '0; expCode <= '0;
      savedPc <= '0; savedSr <= '0; sr <= '0; vbr <= '0; rcWay <= '0;
      branchTarget <= '0;
    end else if (strobe.trap) begin
      pteHi        <= {accAddr[AW-1:PAGE_BITS], pteHi[PAGE_BITS-1:0]};
      faultAddr    <= accAddr;
      expCode      <= EXC_CODE;
      savedPc      <= accDelaySlot ? accBranchPc : accPc;
      savedSr      <= sr;
      sr           <= sr | srTrapMask;
      rcWay        <= tlbWay;
      branchTarget <= vbr + VEC_OFS;
    end else if (strobe.regWr) begin
      case (regSel)
        SEL_PTEHI: pteHi <= regWdata;
        SEL_PTELO: pteLo <= regWdata;
        SEL_SR:    sr    <= regWdata;
        SEL_VBR:   vbr   <= regWdata;
        SEL_RC:    rcWay <= regWdata[WAY_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tlbWrEn <= 1'b0; tlbWrWay <= '0; tlbWrHi <= '0; tlbWrLo <= '0;
    end else begin
      tlbWrEn <= strobe.load;
      if (strobe.load) begin
        tlbWrWay <= rcWay;
        tlbWrHi  <= pteHi;
        tlbWrLo  <= pteLo;
      end
    end
  end
endmodule

// File: rtl/dtrap_top.sv
module dtrap_top
  import dtrap_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        accValid,
  input  logic        accWrite,
  input  logic [31:0] accAddr,
  input  logic [31:0] accPc,
  input  logic        accDelaySlot,
  input  logic [31:0] accBranchPc,
  input  logic        tlbHit,
  input  logic        tlbRightsOk,
  input  logic        tlbDirty,
  input  logic [1:0]  tlbWay,
  input  logic        ldtlbCmd,
  input  logic        regWe,
  input  logic [2:0]  regSel,
  input  logic [31:0] regWdata,
  output logic        storeCommit,
  output logic        trapTaken,
  output logic        stuckFault,
  output logic [31:0] branchTarget,
  output logic [31:0] pteHiOut,
  output logic [31:0] pteLoOut,
  output logic [31:0] faultAddrOut,
  output logic [11:0] expCodeOut,
  output logic [31:0] savedPcOut,
  output logic [31:0] savedSrOut,
  output logic [31:0] srOut,
  output logic [31:0] vbrOut,
  output logic [1:0]  rcWayOut,
  output logic        tlbWrEn,
  output logic [1:0]  tlbWrWay,
  output logic [31:0] tlbWrHi,
  output logic [31:0] tlbWrLo
);
  dtrapStrobe_t strobe;

  dtrap_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .accValid(accValid), .accWrite(accWrite),
    .tlbHit(tlbHit), .tlbRightsOk(tlbRightsOk), .tlbDirty(tlbDirty),
    .blocked(srOut[SR_BL]), .ldtlbCmd(ldtlbCmd), .regWe(regWe),
    .strobe(strobe), .storeCommit(storeCommit), .trapTaken(trapTaken),
    .stuckFault(stuckFault)
  );

  dtrap_dp #(.AW(32), .WAYS(4), .PAGE_BITS(12)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .accAddr(accAddr), .accPc(accPc),
    .accDelaySlot(accDelaySlot), .accBranchPc(accBranchPc), .tlbWay(tlbWay),
    .regSel(regSel), .regWdata(regWdata), .branchTarget(branchTarget),
    .pteHi(pteHiOut), .pteLo(pteLoOut), .faultAddr(faultAddrOut),
    .expCode(expCodeOut), .savedPc(savedPcOut), .savedSr(savedSrOut),
    .sr(srOut), .vbr(vbrOut), .rcWay(rcWayOut), .tlbWrEn(tlbWrEn),
    .tlbWrWay(tlbWrWay), .tlbWrHi(tlbWrHi), .tlbWrLo(tlbWrLo)
  );
endmodule

// File: rtl/dtrap_chk.sv
module dtrap_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        accValid,
  input logic        accWrite,
  input logic [31:0] accAddr,
  input logic [31:0] accPc,
  input logic        accDelaySlot,
  input logic [31:0] accBranchPc,
  input logic        tlbHit,
  input logic        tlbRightsOk,
  input logic        tlbDirty,
  input logic [1:0]  tlbWay,
  input logic        ldtlbCmd,
  input logic        storeCommit,
  input logic        trapTaken,
  input logic        stuckFault,
  input logic [31:0] branchTarget,
  input logic [31:0] pteHiOut,
  input logic [11:0] expCodeOut,
  input logic [31:0] savedPcOut,
  input logic [31:0] savedSrOut,
  input logic [31:0] srOut,
  input logic [31:0] vbrOut,
  input logic [1:0]  rcWayOut,
  input logic        tlbWrEn,
  input logic [1:0]  tlbWrWay
);
  logic cleanStore;
  assign cleanStore = accValid && accWrite && tlbHit && tlbRightsOk && !tlbDirty;

  assert_trap_fires_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cleanStore && !srOut[28]) |=> trapTaken);
  assert_no_trap_else_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cleanStore |=> !trapTaken);
  assert_miss_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tlbHit || !tlbRightsOk) |-> !storeCommit);
  assert_vpn_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cleanStore && !srOut[28]) |=> pteHiOut[31:12] == $past(accAddr[31:12]));
  assert_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trapTaken |-> expCodeOut == 12'h080);
  assert_spc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cleanStore && !srOut[28]) |=>
      savedPcOut == ($past(accDelaySlot) ? $past(accBranchPc) : $past(accPc)));
  assert_ssr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cleanStore && !srOut[28]) |=> savedSrOut == $past(srOut));
  assert_srbits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trapTaken |-> srOut[30:28] == 3'b111);
  assert_way_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cleanStore && !srOut[28]) |=> rcWayOut == $past(tlbWay));
  assert_vector_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cleanStore && !srOut[28]) |=> branchTarget == $past(vbrOut) + 32'h100);
  assert_stuck_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cleanStore && srOut[28]) |=> stuckFault && !trapTaken && $stable(savedPcOut));
  assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ldtlbCmd |=> tlbWrEn && tlbWrWay == $past(rcWayOut));
endmodule

bind dtrap_top dtrap_chk u_chk (.*);

// File: tb/dtrap_top_bench.sv
module dtrap_top_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        accValid = 0, accWrite = 0, accDelaySlot = 0;
  logic [31:0] accAddr = 0, accPc = 0, accBranchPc = 0, regWdata = 0;
  logic        tlbHit = 0, tlbRightsOk = 0, tlbDirty = 0, ldtlbCmd = 0, regWe = 0;
  logic [1:0]  tlbWay = 0;
  logic [2:0]  regSel = 0;
  logic        storeCommit, trapTaken, stuckFault, tlbWrEn;
  logic [31:0] branchTarget, pteHiOut, pteLoOut, faultAddrOut, savedPcOut;
  logic [31:0] savedSrOut, srOut, vbrOut, tlbWrHi, tlbWrLo;
  logic [11:0] expCodeOut;
  logic [1:0]  rcWayOut, tlbWrWay;

  dtrap_top u_dtrap_top (.*);

  int checks = 0, failures = 0;
  logic [31:0] mPteHi, mPteLo, mFault, mSpc, mSsr, mSr, mVbr, mBt, mWrHi, mWrLo;
  logic [11:0] mExp;
  logic [1:0]  mRc, mWrWay;
  logic        mTrap, mStuck, mWrEn;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic expCommit();
    return accValid && accWrite && tlbHit && tlbRightsOk && tlbDirty;
  endfunction

  task automatic modelReset();
    mPteHi = 0; mPteLo = 0; mFault = 0; mSpc = 0; mSsr = 0; mSr = 0; mVbr = 0;
    mBt = 0; mExp = 0; mRc = 0; mTrap = 0; mStuck = 0; mWrEn = 0;
    mWrHi = 0; mWrLo = 0; mWrWay = 0;
  endtask

  task automatic compareAll();
    chk("R1 trapTaken", {31'b0, trapTaken}, {31'b0, mTrap});
    chk("R9 stuckFault", {31'b0, stuckFault}, {31'b0, mStuck});
    chk("R3 pteHi", pteHiOut, mPteHi);
    chk("R11 pteLo", pteLoOut, mPteLo);
    chk("R3 faultAddr", faultAddrOut, mFault);
    chk("R4 expCode", {20'b0, expCodeOut}, {20'b0, mExp});
    chk("R5 savedPc", savedPcOut, mSpc);
    chk("R6 savedSr", savedSrOut, mSsr);
    chk("R6 sr", srOut, mSr);
    chk("R11 vbr", vbrOut, mVbr);
    chk("R7 rcWay", {30'b0, rcWayOut}, {30'b0, mRc});
    chk("R10 tlbWrEn", {31'b0, tlbWrEn}, {31'b0, mWrEn});
    if (mTrap) chk("R8 branchTarget", branchTarget, mBt);
    if (mWrEn) begin
      chk("R10 tlbWrWay", {30'b0, tlbWrWay}, {30'b0, mWrWay});
      chk("R10 tlbWrHi", tlbWrHi, mWrHi);
      chk("R10 tlbWrLo", tlbWrLo, mWrLo);
    end
  endtask

  // inputs already driven; advance one edge and compare against the model
  task automatic step();
    logic clean, take;
    #1;
    chk("R2 storeCommit", {31'b0, storeCommit}, {31'b0, expCommit()});
    clean = accValid && accWrite && tlbHit && tlbRightsOk && !tlbDirty;
    take = clean && !mSr[28];
    mStuck = clean && mSr[28];
    mTrap = take;
    mWrEn = ldtlbCmd;
    if (ldtlbCmd) begin mWrHi = mPteHi; mWrLo = mPteLo; mWrWay = mRc; end
    if (take) begin
      mPteHi = {accAddr[31:12], mPteHi[11:0]};
      mFault = accAddr; mExp = 12'h080;
      mSpc = accDelaySlot ? accBranchPc : accPc;
      mSsr = mSr; mSr = mSr | 32'h7000_0000;
      mRc = tlbWay; mBt = mVbr + 32'h100;
    end else if (regWe) begin
      case (regSel)
        3'd0: mPteHi = regWdata;
        3'd1: mPteLo = regWdata;
        3'd2: mSr = regWdata;
        3'd3: mVbr = regWdata;
        3'd4: mRc = regWdata[1:0];
        default: ;
      endcase
    end
    @(posedge clk); #1;
    compareAll();
    @(negedge clk);
  endtask

  task automatic idle();
    accValid = 0; accWrite = 0; ldtlbCmd = 0; regWe = 0; accDelaySlot = 0;
  endtask

  task automatic wreg(input logic [2:0] s, input logic [31:0] d);
    idle(); regWe = 1; regSel = s; regWdata = d; step(); regWe = 0;
  endtask

  task automatic store(input logic [31:0] a, input logic h, input logic ok,
                       input logic d, input logic [1:0] w, input logic ds);
    idle(); accValid = 1; accWrite = 1; accAddr = a; accPc = a ^ 32'h5555_0000;
    accBranchPc = a ^ 32'hAAAA_0000; accDelaySlot = ds;
    tlbHit = h; tlbRightsOk = ok; tlbDirty = d; tlbWay = w; step(); idle();
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1; compareAll(); // R12 reset state
    chk("R12 trap low", {31'b0, trapTaken}, 32'd0);
    // R11 register port, including an unused code
    wreg(3'd3, 32'h8000_0000);
    wreg(3'd0, 32'h0000_0ABC);
    wreg(3'd1, 32'h1234_5678);
    wreg(3'd6, 32'hFFFF_FFFF);
    // R2 miss, rights fail, dirty store, read: no trap
    store(32'h1111_2000, 0, 1, 0, 2'd1, 0);
    store(32'h1111_2000, 1, 0, 0, 2'd1, 0);
    store(32'h1111_2000, 1, 1, 1, 2'd1, 0);
    idle(); accValid = 1; tlbHit = 1; tlbRightsOk = 1; tlbDirty = 0; step(); idle();
    // R1 R3 R4 R6 R7 R8 trap
    store(32'hCAFE_B123, 1, 1, 0, 2'd2, 0);
    // R9 blocked trap, then unblock
    store(32'h0BAD_F00D, 1, 1, 0, 2'd3, 0);
    wreg(3'd2, 32'h0000_00F0);
    // R5 delay-slot trap
    store(32'h7777_1004, 1, 1, 0, 2'd3, 1);
    // R10 choose way then load
    wreg(3'd4, 32'h0000_0001);
    idle(); ldtlbCmd = 1; step(); idle();
    wreg(3'd2, 32'h0);
    // R11 trap beats same-cycle write
    idle(); accValid = 1; accWrite = 1; accAddr = 32'h4444_5000; accPc = 32'h10;
    tlbHit = 1; tlbRightsOk = 1; tlbDirty = 0; tlbWay = 0;
    regWe = 1; regSel = 3'd3; regWdata = 32'h9999_0000; ldtlbCmd = 1; step(); idle();
    // random phase
    for (int i = 0; i < 3000; i++) begin
      accValid = $urandom_range(0, 3) != 0;
      accWrite = $urandom_range(0, 1);
      accAddr = $urandom; accPc = $urandom; accBranchPc = $urandom;
      accDelaySlot = $urandom_range(0, 1);
      tlbHit = $urandom_range(0, 4) != 0;
      tlbRightsOk = $urandom_range(0, 4) != 0;
      tlbDirty = $urandom_range(0, 1);
      tlbWay = 2'($urandom_range(0, 3));
      ldtlbCmd = $urandom_range(0, 5) == 0;
      regWe = $urandom_range(0, 3) == 0;
      regSel = 3'($urandom_range(0, 5));
      regWdata = $urandom;
      if (regSel == 3'd2) regWdata[28] = $urandom_range(0, 3) == 0;
      step();
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule